// File: doc/BRIEF.md
# Multi-Window Base Address Decoder

This block sits between a target's configuration space and its transaction path. It holds no register state of its own for the windows. Each cycle it receives six programmed base values, a type bit per window (I/O or memory) and a power-of-two size per window, expressed as log2 of the byte count. An incoming request address is compared against every active window. One clock later the block reports which window claimed the address, as a one-hot vector and as an index, together with the byte offset inside that window. A miss flag is raised when no window claims it.

A window's effective base is its programmed value plus a fixed space origin. One origin is used for I/O windows and a different one for memory windows; both are elaboration parameters. A window with a programmed value of zero is switched off. Whenever any programmed value or type bit changes, a one-cycle update pulse tells downstream routing logic to refresh its view of the address map.

Top module: `bar_window_decoder`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, rsp_valid, rsp_hit, rsp_index, rsp_offset, rsp_miss and range_update are all zero.
- R2: A window whose programmed base value is zero never claims an address, whatever its size and type.
- R3: The effective base of window i is its programmed value plus IO_ORIGIN when bar_is_io[i] is 1, or plus MEM_ORIGIN when it is 0, taken modulo 2^ADDR_W.
- R4: Let k be the window's size field, with 0 <= k <= ADDR_W. The window claims an address when the address bits at positions k and above equal the same bits of its effective base. Position base+2^k-1 is therefore inside the window and base+2^k is outside. k = ADDR_W claims every address.
- R5: When several windows claim an address, the lowest-numbered one wins. rsp_hit then has exactly one bit set, at position rsp_index.
- R6: When a request is claimed by no window, rsp_miss is 1 and rsp_hit, rsp_index and rsp_offset are zero.
- R7: On a hit, rsp_offset equals the request address with every bit at position k and above cleared, where k is the winning window's size field.
- R8: A request presented with req_valid high is answered on rsp_* right after the next rising clock edge. A cycle with req_valid low yields rsp_valid = 0 and all other rsp_* outputs zero.
- R9: A change in any bar_base or bar_is_io bit between two rising edges makes range_update 1 for the cycle after the second edge. If the inputs then stay steady, range_update returns to 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request address is present |
| req_addr | input | ADDR_W | Request address |
| bar_base | input | NUM_WIN*ADDR_W | Programmed base per window, window i in bits [i*ADDR_W +: ADDR_W] |
| bar_is_io | input | NUM_WIN | 1 = I/O window, 0 = memory window |
| bar_size_log2 | input | NUM_WIN*SZ_W | log2 of window size, window i in bits [i*SZ_W +: SZ_W] |
| rsp_valid | output | 1 | Registered response present |
| rsp_hit | output | NUM_WIN | One-hot winning window |
| rsp_index | output | IDX_W | Index of winning window |
| rsp_offset | output | ADDR_W | Byte offset inside winning window |
| rsp_miss | output | 1 | No window claimed the request |
| range_update | output | 1 | One-cycle pulse after a base or type change |

## Verification
The hardest situation to reach from the ports is two or more active windows that claim the same address while some of them differ in type and size. Random programming almost never produces it. Directed steps therefore program identical bases on separate windows and then switch the lower one off, which checks both the priority order and the effect of a zero base. The other corners are also set up on purpose: the last byte inside a window, the first byte past it, a size field of ADDR_W, and a base whose sum with the space origin wraps around. These run alongside seeded random maps whose request addresses are mostly aimed inside a chosen window.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

   // width of an index able to name n items, at least one bit
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // width of a field able to hold values 0..w
   function automatic int size_field_width(input int w);
      return $clog2(w + 1);
   endfunction

endpackage

// File: rtl/bwd_window.sv
module bwd_window
   import bwd_pkg::*;
#(
   parameter int              ADDR_W     = 32,
   parameter int              SZ_W       = size_field_width(ADDR_W),
   parameter logic [ADDR_W-1:0] IO_ORIGIN  = '0,
   parameter logic [ADDR_W-1:0] MEM_ORIGIN = '0
) (
   input  logic [ADDR_W-1:0] prog,
   input  logic              is_io,
   input  logic [SZ_W-1:0]   size_log2,
   input  logic [ADDR_W-1:0] addr,
   output logic              active,
   output logic              match,
   output logic [ADDR_W-1:0] low_part
);

   logic [ADDR_W-1:0] eff_base;
   logic [ADDR_W-1:0] upper_mask;

   // effective base: programmed value moved into its space
   assign eff_base = prog + (is_io ? IO_ORIGIN : MEM_ORIGIN);
   assign active   = (prog != '0);

   // bits at or above the size field take part in the comparison
   always_comb begin
      for (int b = 0; b < ADDR_W; b++) begin
         upper_mask[b] = (b >= int'(size_log2));
      end
   end

   assign match    = active && (((addr ^ eff_base) & upper_mask) == '0);
   assign low_part = addr & ~upper_mask;

endmodule

// File: rtl/bwd_pick.sv
module bwd_pick
   import bwd_pkg::*;
#(
   parameter int N     = 6,
   parameter int IDX_W = idx_width(N)
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     onehot,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   // scan downwards so the lowest set position is written last
   always_comb begin
      onehot = '0;
      idx    = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            onehot    = '0;
            onehot[i] = 1'b1;
            idx       = IDX_W'(i);
         end
      end
   end

   assign any = |req;

endmodule

// File: rtl/bwd_change.sv
module bwd_change #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   output logic         pulse
);

   logic [W-1:0] seen_q;
   logic         pulse_q;

   // seen_q keeps following the input during reset, so that the first
   // edge after reset compares against the value held in reset
   always_ff @(posedge clk) begin
      seen_q <= cur;
      if (!rst_n) begin
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= (cur != seen_q);
      end
   end

   assign pulse = pulse_q;

endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
   import bwd_pkg::*;
#(
   parameter int                NUM_WIN    = 6,
   parameter int                ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] IO_ORIGIN  = 32'h0100_0000,
   parameter logic [ADDR_W-1:0] MEM_ORIGIN = 32'h4000_0000,
   localparam int               SZ_W       = size_field_width(ADDR_W),
   localparam int               IDX_W      = idx_width(NUM_WIN)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [NUM_WIN*ADDR_W-1:0] bar_base,
   input  logic [NUM_WIN-1:0]        bar_is_io,
   input  logic [NUM_WIN*SZ_W-1:0]   bar_size_log2,
   output logic                      rsp_valid,
   output logic [NUM_WIN-1:0]        rsp_hit,
   output logic [IDX_W-1:0]          rsp_index,
   output logic [ADDR_W-1:0]         rsp_offset,
   output logic                      rsp_miss,
   output logic                      range_update
);

   localparam int CHG_W = NUM_WIN * (ADDR_W + 1);

   // elaboration-time parameter checks
   if (NUM_WIN < 1 || NUM_WIN > 64) begin : g_bad_num_win
      $error("bar_window_decoder: NUM_WIN must be within 1..64");
   end
   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr_w
      $error("bar_window_decoder: ADDR_W must be within 8..64");
   end

   logic [NUM_WIN-1:0] win_active;
   logic [NUM_WIN-1:0] win_match;
   logic [ADDR_W-1:0]  win_low [NUM_WIN];

   // one comparator per window
   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      bwd_window #(
         .ADDR_W     (ADDR_W),
         .SZ_W       (SZ_W),
         .IO_ORIGIN  (IO_ORIGIN),
         .MEM_ORIGIN (MEM_ORIGIN)
      ) u_win (
         .prog      (bar_base[g*ADDR_W +: ADDR_W]),
         .is_io     (bar_is_io[g]),
         .size_log2 (bar_size_log2[g*SZ_W +: SZ_W]),
         .addr      (req_addr),
         .active    (win_active[g]),
         .match     (win_match[g]),
         .low_part  (win_low[g])
      );
   end

   logic [NUM_WIN-1:0] pick_onehot;
   logic [IDX_W-1:0]   pick_idx;
   logic               pick_any;

   bwd_pick #(
      .N     (NUM_WIN),
      .IDX_W (IDX_W)
   ) u_pick (
      .req    (win_match & win_active),
      .onehot (pick_onehot),
      .idx    (pick_idx),
      .any    (pick_any)
   );

   // offset of the winner, AND-OR selected by the one-hot vector
   logic [ADDR_W-1:0] pick_offset;
   always_comb begin
      pick_offset = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         pick_offset = pick_offset | (pick_onehot[i] ? win_low[i] : '0);
      end
   end

   // response register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= '0;
         rsp_index  <= '0;
         rsp_offset <= '0;
         rsp_miss   <= 1'b0;
      end else if (req_valid) begin
         rsp_valid  <= 1'b1;
         rsp_hit    <= pick_onehot;
         rsp_index  <= pick_idx;
         rsp_offset <= pick_offset;
         rsp_miss   <= ~pick_any;
      end else begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= '0;
         rsp_index  <= '0;
         rsp_offset <= '0;
         rsp_miss   <= 1'b0;
      end
   end

   // map change notification on base or type changes
   bwd_change #(
      .W (CHG_W)
   ) u_change (
      .clk   (clk),
      .rst_n (rst_n),
      .cur   ({bar_is_io, bar_base}),
      .pulse (range_update)
   );

endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
   parameter int NUM_WIN = 6,
   parameter int ADDR_W  = 32,
   parameter int IDX_W   = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      req_valid,
   input logic [NUM_WIN*ADDR_W-1:0] bar_base,
   input logic [NUM_WIN-1:0]        bar_is_io,
   input logic                      rsp_valid,
   input logic [NUM_WIN-1:0]        rsp_hit,
   input logic [IDX_W-1:0]          rsp_index,
   input logic [ADDR_W-1:0]         rsp_offset,
   input logic                      rsp_miss,
   input logic                      range_update
);

   assert_hit_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_hit));

   assert_hit_matches_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_miss) |-> (rsp_hit == (NUM_WIN'(1) << rsp_index)));

   assert_miss_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_valid && rsp_hit == '0 && rsp_index == '0 && rsp_offset == '0));

   assert_answer_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && rsp_hit == '0 && !rsp_miss && rsp_offset == '0));

   assert_valid_has_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_miss || rsp_hit != '0));

   assert_update_follows_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ({bar_is_io, bar_base} != $past({bar_is_io, bar_base})) |=> range_update);

endmodule

bind bar_window_decoder bwd_checker #(
   .NUM_WIN (NUM_WIN),
   .ADDR_W  (ADDR_W),
   .IDX_W   (IDX_W)
) u_bwd_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .bar_base     (bar_base),
   .bar_is_io    (bar_is_io),
   .rsp_valid    (rsp_valid),
   .rsp_hit      (rsp_hit),
   .rsp_index    (rsp_index),
   .rsp_offset   (rsp_offset),
   .rsp_miss     (rsp_miss),
   .range_update (range_update)
);

// File: tb/bar_window_decoder_bench.sv
`timescale 1ns/1ps
module bar_window_decoder_bench;

   localparam int          NW   = 6;
   localparam int          AW   = 32;
   localparam int          SZW  = 6;
   localparam int          IXW  = 3;
   localparam logic [31:0] IO_O = 32'h0100_0000;
   localparam logic [31:0] MEM_O = 32'h4000_0000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [AW-1:0]     req_addr = '0;
   logic [NW*AW-1:0]  bar_base = '0;
   logic [NW-1:0]     bar_is_io = '0;
   logic [NW*SZW-1:0] bar_size_log2 = '0;
   logic              rsp_valid;
   logic [NW-1:0]     rsp_hit;
   logic [IXW-1:0]    rsp_index;
   logic [AW-1:0]     rsp_offset;
   logic              rsp_miss;
   logic              range_update;

   always #2 clk = ~clk;

   bar_window_decoder #(
      .NUM_WIN    (NW),
      .ADDR_W     (AW),
      .IO_ORIGIN  (IO_O),
      .MEM_ORIGIN (MEM_O)
   ) u_bar_window_decoder (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_addr      (req_addr),
      .bar_base      (bar_base),
      .bar_is_io     (bar_is_io),
      .bar_size_log2 (bar_size_log2),
      .rsp_valid     (rsp_valid),
      .rsp_hit       (rsp_hit),
      .rsp_index     (rsp_index),
      .rsp_offset    (rsp_offset),
      .rsp_miss      (rsp_miss),
      .range_update  (range_update)
   );

   logic [31:0] cfg_prog [NW];
   logic        cfg_io   [NW];
   int          cfg_k    [NW];

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   task automatic push_cfg();
      for (int i = 0; i < NW; i++) begin
         bar_base[i*AW +: AW]        = cfg_prog[i];
         bar_is_io[i]                = cfg_io[i];
         bar_size_log2[i*SZW +: SZW] = SZW'(cfg_k[i]);
      end
   endtask

   task automatic clear_cfg();
      for (int i = 0; i < NW; i++) begin
         cfg_prog[i] = '0;
         cfg_io[i]   = 1'b0;
         cfg_k[i]    = 12;
      end
   endtask

   // reference decode built from the requirements
   function automatic void model(input logic [31:0] a, output logic [NW-1:0] hit,
                                 output logic [IXW-1:0] idx, output logic [31:0] off,
                                 output logic miss);
      logic [31:0] eff;
      hit = '0; idx = '0; off = '0; miss = 1'b1;
      for (int i = 0; i < NW; i++) begin
         if (miss && cfg_prog[i] != 0) begin
            eff = cfg_prog[i] + (cfg_io[i] ? IO_O : MEM_O);
            if ((a >> cfg_k[i]) == (eff >> cfg_k[i])) begin
               miss   = 1'b0;
               hit[i] = 1'b1;
               idx    = IXW'(i);
               off    = a & ((32'h1 << cfg_k[i]) - 32'h1);
            end
         end
      end
   endfunction

   function automatic logic [31:0] eff_of(input int i);
      return cfg_prog[i] + (cfg_io[i] ? IO_O : MEM_O);
   endfunction

   // called at a falling edge; checks at the following falling edge
   task automatic send(input logic [31:0] a, input string req);
      logic [NW-1:0]  eh;
      logic [IXW-1:0] ei;
      logic [31:0]    eo;
      logic           em;
      push_cfg();
      req_valid = 1'b1;
      req_addr  = a;
      model(a, eh, ei, eo, em);
      @(negedge clk);
      n_checks++;
      if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_index !== ei ||
          rsp_offset !== eo || rsp_miss !== em) begin
         n_fail++;
         $display("FAIL %s addr=%h actual v=%b hit=%b idx=%0d off=%h miss=%b expected v=1 hit=%b idx=%0d off=%h miss=%b",
                  req, a, rsp_valid, rsp_hit, rsp_index, rsp_offset, rsp_miss, eh, ei, eo, em);
      end
   endtask

   task automatic idle_check(input string req);
      req_valid = 1'b0;
      req_addr  = 32'hDEAD_BEEF;
      @(negedge clk);
      n_checks++;
      if (rsp_valid !== 1'b0 || rsp_hit !== '0 || rsp_index !== '0 ||
          rsp_offset !== '0 || rsp_miss !== 1'b0) begin
         n_fail++;
         $display("FAIL %s actual v=%b hit=%b idx=%0d off=%h miss=%b expected all zero",
                  req, rsp_valid, rsp_hit, rsp_index, rsp_offset, rsp_miss);
      end
   endtask

   task automatic upd_check(input logic exp, input string req);
      n_checks++;
      if (range_update !== exp) begin
         n_fail++;
         $display("FAIL %s range_update actual=%b expected=%b", req, range_update, exp);
      end
   endtask

   // apply new config at a falling edge, then watch the pulse for two cycles
   task automatic reprogram(input logic exp_pulse, input string req);
      push_cfg();
      req_valid = 1'b0;
      @(negedge clk);
      upd_check(exp_pulse, req);
      @(negedge clk);
      upd_check(1'b0, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL R8 watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [NW*AW-1:0] old_b;
      logic [NW-1:0]    old_t;
      int               w;
      void'($urandom(32'h5EED_0042));
      clear_cfg();
      push_cfg();
      repeat (4) @(negedge clk);
      // R1: reset state
      n_checks++;
      if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_index !== 0 || rsp_offset !== 0 ||
          rsp_miss !== 0 || range_update !== 0) begin
         n_fail++;
         $display("FAIL R1 in reset actual v=%b hit=%b upd=%b expected zeros", rsp_valid, rsp_hit, range_update);
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_checks++;
      if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_miss !== 0 || range_update !== 0) begin
         n_fail++;
         $display("FAIL R1 after reset actual v=%b hit=%b upd=%b expected zeros", rsp_valid, rsp_hit, range_update);
      end

      // R2/R6: nothing programmed gives a miss
      send(32'h4000_0000, "R2 R6 empty map");

      // R3/R4/R7: memory window
      cfg_prog[0] = 32'h0001_0000; cfg_io[0] = 0; cfg_k[0] = 12;
      reprogram(1'b1, "R9 first program");
      send(32'h4001_0123, "R3 R7 memory hit");
      send(32'h4001_0FFF, "R4 last byte inside");
      send(32'h4001_1000, "R4 first byte outside");
      send(32'h4000_FFFF, "R4 byte below base");
      // R3: I/O window
      cfg_prog[2] = 32'h0000_2000; cfg_io[2] = 1; cfg_k[2] = 8;
      reprogram(1'b1, "R9 io window");
      send(32'h0100_20FF, "R3 io hit");
      send(32'h4000_20FF, "R3 io not in mem space");
      // R5: overlap, lowest wins
      cfg_prog[1] = 32'h0800_0000; cfg_io[1] = 0; cfg_k[1] = 16;
      cfg_prog[4] = 32'h0800_0000; cfg_io[4] = 0; cfg_k[4] = 20;
      reprogram(1'b1, "R9 overlap setup");
      send(32'h4800_ABCD, "R5 lowest wins");
      send(32'h4801_0000, "R5 only upper window");
      cfg_prog[1] = '0;
      reprogram(1'b1, "R9 window off");
      send(32'h4800_ABCD, "R2 zero base disables");
      // R9: type flip alone
      cfg_io[3] = 1'b1;
      reprogram(1'b1, "R9 type bit change");
      // size change alone does not count
      cfg_k[3] = 5;
      reprogram(1'b0, "R9 size only no pulse");
      // R4: full-space window
      clear_cfg();
      cfg_prog[5] = 32'h0000_0010; cfg_k[5] = 32;
      reprogram(1'b1, "R9 full window");
      send(32'h1234_5678, "R4 R7 full-space window");
      // R3: wraparound
      clear_cfg();
      cfg_prog[3] = 32'hC000_0000; cfg_k[3] = 16;
      reprogram(1'b1, "R9 wrap program");
      send(32'h0000_1234, "R3 base wraps");
      send(32'hC000_1234, "R3 unwrapped address misses");
      // R4: size field zero
      cfg_prog[0] = 32'h0000_0100; cfg_k[0] = 0;
      reprogram(1'b1, "R9 tiny window");
      send(32'h4000_0100, "R4 one-byte window hit");
      send(32'h4000_0101, "R4 one-byte window miss");
      idle_check("R8 idle cycle");

      // random maps
      for (int r = 0; r < 40; r++) begin
         old_b = bar_base; old_t = bar_is_io;
         for (int i = 0; i < NW; i++) begin
            cfg_k[i]  = 4 + int'($urandom % 17);
            cfg_io[i] = $urandom % 2;
            if ($urandom % 4 == 0) cfg_prog[i] = '0;
            else begin
               cfg_prog[i] = $urandom & ~((32'h1 << cfg_k[i]) - 1);
               if (cfg_prog[i] == 0) cfg_prog[i] = 32'h1 << cfg_k[i];
            end
            // occasionally copy a lower window for overlap
            if (i > 0 && $urandom % 5 == 0) begin
               cfg_prog[i] = cfg_prog[i-1]; cfg_io[i] = cfg_io[i-1];
            end
         end
         push_cfg();
         reprogram((old_b != bar_base) || (old_t != bar_is_io), "R9 random reprogram");
         for (int q = 0; q < 12; q++) begin
            w = int'($urandom % NW);
            if ($urandom % 10 < 7)
               send(eff_of(w) + ($urandom & ((32'h1 << cfg_k[w]) - 1)), "R4 R5 R7 random aimed");
            else
               send($urandom, "R6 random address");
            if ($urandom % 8 == 0) idle_check("R8 random idle");
         end
      end

      req_valid = 1'b0;
      @(negedge clk);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule